// File: doc/BRIEF.md
# Clear-to-Send Change Interrupt Unit

This block raises an interrupt whenever the clear-to-send modem input of a UART changes level, in either direction. The input is first brought into the UART clock domain through a flop chain. A change on the synchronised line sets a sticky raw status bit. A mask bit decides whether that status reaches the interrupt output. Software uses a simple write strobe and a combinational read port to inspect the status, to program the mask and to acknowledge the interrupt.

Acknowledging works in an unusual way. The acknowledge address writes a hidden one-bit clear register. The status drops only when that register goes from 0 to 1, never because it sits at 1. Once the status reads 0, hardware returns the hidden bit to 0 by itself. If a new line change and a clear rising edge hit the status in the same cycle, the change wins. The hidden bit then stays at 1, and only a write of 0 followed, at least one clock later, by a write of 1 can produce a fresh clear. Software that must be sure of a clear therefore always writes 0 and then 1.

Top module: `mdm_edge_irq`

## Requirements
- R1: After reset the raw status, the mask and `irq_o` are 0. A line level that is already present when reset is released produces no status.
- R2: A 0-to-1 change of `cts_i` sets the raw status. The status becomes visible on the third rising clock edge after the input changes.
- R3: A 1-to-0 change of `cts_i` sets the raw status, with the same three-edge latency.
- R4: Writing 1 to the clear address (address 2, `wr_data`=1) while the hidden clear bit is 0 and no line change is pending clears the raw status. The status reads 0 two rising edges after the write is sampled.
- R5: The hidden clear bit returns to 0 by itself once the status is 0. A later single write of 1 therefore clears a newly set status.
- R6: When a line change and a clear rising edge reach the status in the same cycle, the status stays 1.
- R7: After the case in R6, a further write of 1 alone leaves the status at 1. A write of 0 followed in the next cycle by a write of 1 clears it.
- R8: A read of the clear address (address 2) returns 0 in every bit.
- R9: `irq_o` equals the raw status AND the mask bit. The mask is written and read at address 1, bit 0. The raw status is read at address 0, bit 0. The masked status is read at address 3, bit 0. The mask never changes the raw status.
- R10: Writing 0 to the clear address leaves the raw status unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | UART clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cts_i | input | 1 | Asynchronous clear-to-send line |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 2 | Write address: 1 mask, 2 clear |
| wr_data | input | 1 | Write data bit |
| rd_addr | input | 2 | Read address: 0 raw, 1 mask, 2 clear, 3 masked |
| rd_data | output | DATA_W | Combinational read data, bit 0 meaningful |
| irq_o | output | 1 | Masked interrupt request |

## Verification
The bench lines up a line change with a clear write to the exact cycle, so that both reach the status together. A design that lets the clear win would drop the status there, and one that rearms the hidden bit on a plain level would clear it on the second write of 1. The bench also holds the line high through reset. A synchroniser without preloading would report a spurious change at that point. Long random runs, compared with a cycle model written from the requirements, catch a clear bit that never rearms, a status that a write of 0 disturbs, and a mask that leaks into the raw bit.

// File: rtl/mei_pkg.sv
package mei_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADR_RAW    = 2'd0,
    ADR_MASK   = 2'd1,
    ADR_CLR    = 2'd2,
    ADR_MASKED = 2'd3
  } mei_addr_e;
endpackage

// File: rtl/mei_rst_sync.sv
module mei_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/mei_cts_edge.sv
module mei_cts_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_i,
  output logic edge_o
);
  localparam int unsigned PRIME_CNT = SYNC_STAGES + 1;
  localparam int unsigned CNT_W     = $clog2(PRIME_CNT + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   prev_q;
  logic [CNT_W-1:0]       cnt_q;
  logic [CNT_W-1:0]       cnt_d;
  logic                   cnt_en;
  logic                   primed;
  logic                   line;

  // synchroniser chain, stage 0 samples the pin
  assign sync_d[0] = cts_i;
  for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_chain
    assign sync_d[g] = sync_q[g-1];
  end

  assign line   = sync_q[SYNC_STAGES-1];
  assign primed = (cnt_q == CNT_W'(PRIME_CNT));
  assign cnt_en = !primed;
  assign cnt_d  = cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= line;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // until the chain holds real samples, no change is reported
  assign edge_o = primed & (line ^ prev_q);

  a_r1_no_edge_before_primed: assert property (
    @(posedge clk) disable iff (!rst_n) !primed |-> !edge_o);
endmodule

// File: rtl/mei_clr_ctl.sv
module mei_clr_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_clr_i,
  input  logic wr_bit_i,
  input  logic status_i,
  output logic rise_o
);
  logic clr_q;
  logic clr_d;
  logic hist_q;

  always_comb begin
    clr_d = clr_q;
    if (wr_clr_i)                clr_d = wr_bit_i;
    else if (clr_q && !status_i) clr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_q  <= 1'b0;
      hist_q <= 1'b0;
    end else begin
      clr_q  <= clr_d;
      hist_q <= clr_q;
    end
  end

  assign rise_o = clr_q & ~hist_q;

  a_r5_self_rearm: assert property (
    @(posedge clk) disable iff (!rst_n)
    clr_q && !status_i && !wr_clr_i |=> !clr_q);

  a_r7_no_rise_while_stuck: assert property (
    @(posedge clk) disable iff (!rst_n)
    clr_q && status_i && !wr_clr_i |=> !rise_o);
endmodule

// File: rtl/mei_status.sv
module mei_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic status_o
);
  logic stat_q;
  logic stat_d;
  logic stat_en;

  assign stat_en = set_i | clr_i;

  always_comb begin
    stat_d = stat_q;
    if (set_i)      stat_d = 1'b1;
    else if (clr_i) stat_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= 1'b0;
    else if (stat_en) stat_q <= stat_d;
  end

  assign status_o = stat_q;

  a_r6_set_wins: assert property (
    @(posedge clk) disable iff (!rst_n) set_i |=> status_o);

  a_r4_clear_on_rise: assert property (
    @(posedge clk) disable iff (!rst_n) clr_i && !set_i |=> !status_o);

  a_r10_hold_without_event: assert property (
    @(posedge clk) disable iff (!rst_n) !set_i && !clr_i |=> $stable(status_o));
endmodule

// File: rtl/mdm_edge_irq.sv
module mdm_edge_irq
  import mei_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2,
  parameter int unsigned DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cts_i,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_o
);
  logic rst_int_n;
  logic cts_edge;
  logic clr_rise;
  logic status;
  logic mask_q;
  logic mask_en;
  logic wr_clr;
  logic rd_bit;

  mei_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_int_n)
  );

  mei_cts_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .cts_i  (cts_i),
    .edge_o (cts_edge)
  );

  assign wr_clr  = wr_en && (mei_addr_e'(wr_addr) == ADR_CLR);
  assign mask_en = wr_en && (mei_addr_e'(wr_addr) == ADR_MASK);

  mei_clr_ctl u_clr (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_clr_i (wr_clr),
    .wr_bit_i (wr_data),
    .status_i (status),
    .rise_o   (clr_rise)
  );

  mei_status u_stat (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .set_i    (cts_edge),
    .clr_i    (clr_rise),
    .status_o (status)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   mask_q <= 1'b0;
    else if (mask_en) mask_q <= wr_data;
  end

  assign irq_o = status & mask_q;

  always_comb begin
    case (mei_addr_e'(rd_addr))
      ADR_RAW:    rd_bit = status;
      ADR_MASK:   rd_bit = mask_q;
      ADR_MASKED: rd_bit = irq_o;
      default:    rd_bit = 1'b0;
    endcase
    rd_data = {{(DATA_W-1){1'b0}}, rd_bit};
  end

  a_r8_clear_reads_zero: assert property (
    @(posedge clk) disable iff (!rst_int_n)
    (mei_addr_e'(rd_addr) == ADR_CLR) |-> (rd_data == '0));

  a_r9_mask_blocks_irq: assert property (
    @(posedge clk) disable iff (!rst_int_n) !mask_q |-> !irq_o);
endmodule

// File: tb/mdm_edge_irq_bench.sv
module mdm_edge_irq_bench;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cts;
  logic          wr_en;
  logic [1:0]    wr_addr;
  logic          wr_data;
  logic [1:0]    rd_addr;
  logic [DW-1:0] rd_data;
  logic          irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  bit cmp_on  = 0;

  always #4 clk = ~clk;

  mdm_edge_irq #(.SYNC_STAGES(2), .RST_STAGES(2), .DATA_W(DW)) u_mdm_edge_irq (
    .clk(clk), .rst_n(rst_n), .cts_i(cts), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq)
  );

  // cycle model built from the requirements (used with a quiet start)
  logic m_s0, m_s1, m_prev, m_clr, m_hist, m_stat, m_mask;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_s0, m_s1, m_prev, m_clr, m_hist, m_stat, m_mask} <= '0;
    end else begin
      logic chg, rise;
      chg  = m_s1 ^ m_prev;
      rise = m_clr & ~m_hist;
      m_s0 <= cts; m_s1 <= m_s0; m_prev <= m_s1;
      m_hist <= m_clr;
      if (wr_en && wr_addr == 2'd2)  m_clr <= wr_data;
      else if (m_clr && !m_stat)     m_clr <= 1'b0;
      if (wr_en && wr_addr == 2'd1)  m_mask <= wr_data;
      if (chg)       m_stat <= 1'b1;
      else if (rise) m_stat <= 1'b0;
    end
  end

  function automatic logic [DW-1:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0:    return DW'(m_stat);
      2'd1:    return DW'(m_mask);
      2'd3:    return DW'(m_stat & m_mask);
      default: return '0;
    endcase
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input string req, input logic [1:0] a, input logic [DW-1:0] exp);
    rd_addr = a;
    #1;
    check(req, rd_data, exp);
  endtask

  task automatic do_reset(input logic line);
    rst_n = 1'b0; cts = line; wr_en = 1'b0; wr_addr = '0; wr_data = 1'b0; rd_addr = '0;
    cyc(4);
    rst_n = 1'b1;
    cyc(8);
  endtask

  initial begin
    do_reset(1'b1);
    rd("R1 raw after reset, line high", 2'd0, 0);
    rd("R1 mask after reset", 2'd1, 0);
    check("R1 irq after reset", DW'(irq), 0);

    cts = 1'b0; cyc(2);
    rd("R3 not yet visible", 2'd0, 0);
    cyc(1);
    rd("R3 falling change sets", 2'd0, 1);

    wr(2'd2, 1'b0); cyc(3);
    rd("R10 write 0 keeps status", 2'd0, 1);

    wr(2'd2, 1'b1); cyc(1);
    rd("R4 clear via rise", 2'd0, 0);
    cyc(3);

    cts = 1'b1; cyc(3);
    rd("R2 rising change sets", 2'd0, 1);
    wr(2'd1, 1'b1); cyc(1);
    check("R9 irq with mask set", DW'(irq), 1);
    rd("R9 masked read", 2'd3, 1);
    wr(2'd2, 1'b1); cyc(3);
    rd("R5 single write clears after rearm", 2'd0, 0);

    cts = 1'b0; cyc(5);
    rd("R3 set before collision", 2'd0, 1);
    // line change and clear rise meet in the same cycle
    cts = 1'b1; @(negedge clk);
    wr(2'd2, 1'b1); cyc(3);
    rd("R6 change wins over clear", 2'd0, 1);
    rd("R8 clear address reads 0", 2'd2, 0);
    wr(2'd2, 1'b1); cyc(3);
    rd("R7 lone write 1 ignored", 2'd0, 1);
    wr(2'd2, 1'b0);
    wr(2'd2, 1'b1); cyc(3);
    rd("R7 write 0 then 1 clears", 2'd0, 0);

    wr(2'd1, 1'b0);
    cts = 1'b0; cyc(4);
    check("R9 irq blocked by mask", DW'(irq), 0);
    rd("R9 raw unaffected by mask", 2'd0, 1);
    wr(2'd1, 1'b1); cyc(1);
    check("R9 irq after unmask", DW'(irq), 1);

    // random phase against the model
    do_reset(1'b0);
    cmp_on = 1'b1;
    void'($urandom(32'h5eed_1234));
    for (int k = 0; k < 4000; k++) begin
      rd_addr = 2'($urandom_range(0, 3));
      #1;
      check("R2 R3 R4 R5 R6 R7 R8 R10 random read", rd_data, exp_read(rd_addr));
      check("R9 random irq", DW'(irq), DW'(m_stat & m_mask));
      if ($urandom_range(0, 7) == 0) cts = ~cts;
      wr_en   = ($urandom_range(0, 3) == 0);
      wr_addr = 2'($urandom_range(0, 3));
      wr_data = 1'($urandom_range(0, 1));
      @(negedge clk);
    end
    wr_en = 1'b0;
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < 100000; w++) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule